// File: doc/BRIEF.md
# MSDU Link List Releaser

This block carries out the release of one MPDU's worth of MSDU buffers held in a single link descriptor. The descriptor is kept locally as a table of seven slots. Each slot holds an MSDU buffer pointer, a 3-bit notify code and a 19-bit buffer timestamp. A separate write port fills the table. A command names the slot where the MPDU starts, the descriptor type and the owner code the buffers go back to.

After accepting a valid command, the block walks forward through consecutive non-null slots. For each MSDU it emits one entry on a valid/ready stream. The entry carries the pointer, the notify code, the timestamp, the owner, first/last markers and a details-valid bit. Each accepted entry clears that slot's pointer to zero, which is the null pointer. When the walk ends and no slot holds a pointer any more, the block pulses a strobe that frees the link descriptor itself. A malformed command is refused with a one-cycle error pulse and changes nothing.

Top module: `mll_releaser`

## Requirements
- R1: After reset, rel_valid, link_free and cmd_err are low, cmd_ready is high, and every slot pointer is null (zero).
- R2: A valid command starting at slot s emits one entry per slot s, s+1, ..., k in ascending order. Each entry carries that slot's pointer, notify code and timestamp as last written. k is the first slot at or after s that is slot 6 or whose next slot holds a null pointer.
- R3: rel_first is set only on the entry for slot s and rel_last only on the entry for slot k. Both are set when s equals k, and no entry carries a null pointer.
- R4: The pointer of every slot whose entry is accepted reads null afterwards. A later command starting at that slot is therefore refused.
- R5: While rel_valid is high and rel_ready is low, the entry stays unchanged. The next entry appears in the cycle after an acceptance.
- R6: A command is refused with cmd_err high for exactly one cycle, starting one cycle after acceptance, and no entry is emitted, in any of these cases: the 4-bit first index is above 6, the 3-bit type is not 1 (MSDU link descriptor), or the start slot holds a null pointer.
- R7: link_free is high for exactly one cycle, the cycle after the final entry is accepted. It is high only if all seven slot pointers are null at that point.
- R8: Every entry echoes the command's 4-bit owner code. rel_dvalid is set exactly when that owner code is not 0, where 0 means the releasing manager itself.
- R9: cmd_ready is low from command acceptance until the final entry of a walk is accepted. No command is taken in that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Slot write strobe |
| wr_slot | input | 4 | Slot index to write (0 to 6; larger values are dropped) |
| wr_ptr | input | 40 | MSDU buffer pointer to store, 0 meaning null |
| wr_ntf | input | 3 | Notify code to store |
| wr_ts | input | 19 | Buffer timestamp to store |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_first | input | 4 | Slot where the MPDU starts |
| cmd_type | input | 3 | Descriptor type, 1 = MSDU link descriptor |
| cmd_owner | input | 4 | Owner code the buffers return to |
| rel_valid | output | 1 | Release entry present |
| rel_ready | input | 1 | Downstream accepts the entry |
| rel_ptr | output | 40 | Released MSDU pointer |
| rel_ntf | output | 3 | Notify code of that MSDU |
| rel_ts | output | 19 | Timestamp of that MSDU |
| rel_owner | output | 4 | Owner code from the command |
| rel_first | output | 1 | First MSDU of the MPDU |
| rel_last | output | 1 | Last MSDU of the MPDU |
| rel_dvalid | output | 1 | Per-MSDU details valid for a foreign owner |
| link_free | output | 1 | One-cycle strobe freeing the link descriptor |
| cmd_err | output | 1 | One-cycle strobe for a refused command |

## Verification
The assertions assume that the write port stays idle while a walk is in progress. In that window a write would change the table behind the walker, and the all-null test that drives link_free would no longer describe the table. The stimulus therefore issues writes only between commands, when cmd_ready is high. Commands are likewise presented only when cmd_ready is high. Within those limits the random part mixes null and non-null slots, out-of-range start indices, wrong descriptor types and a stalling consumer.

// File: rtl/mll_pkg.sv
package mll_pkg;
  localparam int PTR_W  = 40;
  localparam int NTF_W  = 3;
  localparam int TS_W   = 19;
  localparam int TYPE_W = 3;
  localparam int IDX_W  = 4;
  localparam int OWN_W  = 4;

  localparam logic [TYPE_W-1:0] TYPE_MSDU_LINK = 3'd1;

  typedef struct packed {
    logic [PTR_W-1:0] ptr;
    logic [NTF_W-1:0] ntf;
    logic [TS_W-1:0]  ts;
  } slot_t;
endpackage

// File: rtl/mll_slot_table.sv
module mll_slot_table
  import mll_pkg::*;
#(
  parameter int NSLOT  = 7,
  parameter int SIDX_W = $clog2(NSLOT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SIDX_W-1:0] wr_idx,
  input  slot_t             wr_data,
  input  logic              clr_en,
  input  logic [SIDX_W-1:0] clr_idx,
  input  logic [SIDX_W-1:0] rd_idx,
  output slot_t             rd_data,
  output logic [NSLOT-1:0]  occ
);
  slot_t mem [NSLOT];

  // One register group per slot; a clear from the walker wins over a write
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        mem[g] <= '0;
      end else if (clr_en && clr_idx == SIDX_W'(g)) begin
        mem[g].ptr <= '0;
      end else if (wr_en && wr_idx == SIDX_W'(g)) begin
        mem[g] <= wr_data;
      end
    end
    assign occ[g] = |mem[g].ptr;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (rd_idx == SIDX_W'(i)) rd_data = mem[i];
    end
  end

  // R4: a cleared slot reads null on the following cycle
  a_r4_slot_nulled: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> !occ[$past(clr_idx)]);
endmodule

// File: rtl/mll_walker.sv
module mll_walker
  import mll_pkg::*;
#(
  parameter int NSLOT      = 7,
  parameter int SIDX_W     = $clog2(NSLOT + 1),
  parameter int SELF_OWNER = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [IDX_W-1:0]  cmd_first,
  input  logic [TYPE_W-1:0] cmd_type,
  input  logic [OWN_W-1:0]  cmd_owner,
  output logic [SIDX_W-1:0] rd_idx,
  input  slot_t             rd_data,
  input  logic [NSLOT-1:0]  occ,
  output logic              clr_en,
  output logic [SIDX_W-1:0] clr_idx,
  output logic              rel_valid,
  input  logic              rel_ready,
  output slot_t             rel_slot,
  output logic [OWN_W-1:0]  rel_owner,
  output logic              rel_first,
  output logic              rel_last,
  output logic              rel_dvalid,
  output logic              link_free,
  output logic              cmd_err
);
  typedef enum logic {S_IDLE, S_EMIT} state_t;

  localparam logic [SIDX_W-1:0] LAST_SLOT = SIDX_W'(NSLOT - 1);

  state_t            st;
  logic [SIDX_W-1:0] cur;
  logic [NSLOT:0]    occ_ext;
  logic [NSLOT-1:0]  occ_after;
  logic              start_ok;
  logic              nxt_last;
  logic              acc;

  always_comb begin
    occ_ext  = {1'b0, occ};
    rd_idx   = (st == S_IDLE) ? cmd_first[SIDX_W-1:0] : cur + 1'b1;
    start_ok = (cmd_first < IDX_W'(NSLOT)) && (cmd_type == TYPE_MSDU_LINK)
               && occ_ext[rd_idx];
    nxt_last = (rd_idx == LAST_SLOT) || !occ_ext[SIDX_W'(rd_idx + 1'b1)];
    acc      = rel_valid && rel_ready;
    clr_en   = acc;
    clr_idx  = cur;
    occ_after = occ;
    for (int i = 0; i < NSLOT; i++) begin
      if (cur == SIDX_W'(i)) occ_after[i] = 1'b0;
    end
  end

  assign cmd_ready = (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      cur        <= '0;
      rel_valid  <= 1'b0;
      rel_slot   <= '0;
      rel_owner  <= '0;
      rel_first  <= 1'b0;
      rel_last   <= 1'b0;
      rel_dvalid <= 1'b0;
      link_free  <= 1'b0;
      cmd_err    <= 1'b0;
    end else begin
      link_free <= 1'b0;
      cmd_err   <= 1'b0;
      case (st)
        S_IDLE: begin
          if (cmd_valid) begin
            if (start_ok) begin
              st         <= S_EMIT;
              cur        <= rd_idx;
              rel_valid  <= 1'b1;
              rel_slot   <= rd_data;
              rel_owner  <= cmd_owner;
              rel_dvalid <= (cmd_owner != OWN_W'(SELF_OWNER));
              rel_first  <= 1'b1;
              rel_last   <= nxt_last;
            end else begin
              cmd_err <= 1'b1;
            end
          end
        end
        S_EMIT: begin
          if (acc) begin
            if (rel_last) begin
              st        <= S_IDLE;
              rel_valid <= 1'b0;
              link_free <= (occ_after == '0);
            end else begin
              cur       <= rd_idx;
              rel_slot  <= rd_data;
              rel_first <= 1'b0;
              rel_last  <= nxt_last;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R5: a stalled entry holds
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    rel_valid && !rel_ready |=> rel_valid && $stable(rel_slot) && $stable(rel_last));
  // R3: no null pointer is ever offered
  a_r3_nonnull: assert property (@(posedge clk) disable iff (rst)
    rel_valid |-> rel_slot.ptr != '0);
  // R3: after a non-final acceptance the next entry is not a first
  a_r3_mid_first: assert property (@(posedge clk) disable iff (rst)
    rel_valid && rel_ready && !rel_last |=> rel_valid && !rel_first);
  // R6: a refusal emits nothing
  a_r6_err_quiet: assert property (@(posedge clk) disable iff (rst)
    cmd_err |-> !rel_valid);
  // R9: no command taken while entries are pending
  a_r9_busy: assert property (@(posedge clk) disable iff (rst)
    rel_valid |-> !cmd_ready);
endmodule

// File: rtl/mll_releaser.sv
module mll_releaser
  import mll_pkg::*;
#(
  parameter int NSLOT      = 7,
  parameter int SELF_OWNER = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_slot,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic [NTF_W-1:0]  wr_ntf,
  input  logic [TS_W-1:0]   wr_ts,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [IDX_W-1:0]  cmd_first,
  input  logic [TYPE_W-1:0] cmd_type,
  input  logic [OWN_W-1:0]  cmd_owner,
  output logic              rel_valid,
  input  logic              rel_ready,
  output logic [PTR_W-1:0]  rel_ptr,
  output logic [NTF_W-1:0]  rel_ntf,
  output logic [TS_W-1:0]   rel_ts,
  output logic [OWN_W-1:0]  rel_owner,
  output logic              rel_first,
  output logic              rel_last,
  output logic              rel_dvalid,
  output logic              link_free,
  output logic              cmd_err
);
  localparam int SIDX_W = $clog2(NSLOT + 1);

  logic              wr_ok;
  slot_t             wr_data;
  slot_t             rd_data;
  slot_t             rel_slot;
  logic [SIDX_W-1:0] rd_idx;
  logic [SIDX_W-1:0] clr_idx;
  logic              clr_en;
  logic [NSLOT-1:0]  occ;

  assign wr_ok   = wr_en && (wr_slot < IDX_W'(NSLOT));
  assign wr_data = '{ptr: wr_ptr, ntf: wr_ntf, ts: wr_ts};

  mll_slot_table #(.NSLOT(NSLOT), .SIDX_W(SIDX_W)) u_table (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_ok),
    .wr_idx  (wr_slot[SIDX_W-1:0]),
    .wr_data (wr_data),
    .clr_en  (clr_en),
    .clr_idx (clr_idx),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .occ     (occ)
  );

  mll_walker #(.NSLOT(NSLOT), .SIDX_W(SIDX_W), .SELF_OWNER(SELF_OWNER)) u_walk (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_first  (cmd_first),
    .cmd_type   (cmd_type),
    .cmd_owner  (cmd_owner),
    .rd_idx     (rd_idx),
    .rd_data    (rd_data),
    .occ        (occ),
    .clr_en     (clr_en),
    .clr_idx    (clr_idx),
    .rel_valid  (rel_valid),
    .rel_ready  (rel_ready),
    .rel_slot   (rel_slot),
    .rel_owner  (rel_owner),
    .rel_first  (rel_first),
    .rel_last   (rel_last),
    .rel_dvalid (rel_dvalid),
    .link_free  (link_free),
    .cmd_err    (cmd_err)
  );

  assign rel_ptr = rel_slot.ptr;
  assign rel_ntf = rel_slot.ntf;
  assign rel_ts  = rel_slot.ts;

  // R7: the free strobe only appears with an empty table
  a_r7_free_empty: assert property (@(posedge clk) disable iff (rst)
    link_free |-> occ == '0);
  // R7: the free strobe lasts a single cycle
  a_r7_free_pulse: assert property (@(posedge clk) disable iff (rst)
    link_free |=> !link_free);
endmodule

// File: tb/mll_releaser_test.sv
module mll_releaser_test;
  import mll_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NSLOT      = 7;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [IDX_W-1:0]  wr_slot = '0;
  logic [PTR_W-1:0]  wr_ptr = '0;
  logic [NTF_W-1:0]  wr_ntf = '0;
  logic [TS_W-1:0]   wr_ts = '0;
  logic              cmd_valid = 1'b0;
  logic              cmd_ready;
  logic [IDX_W-1:0]  cmd_first = '0;
  logic [TYPE_W-1:0] cmd_type = '0;
  logic [OWN_W-1:0]  cmd_owner = '0;
  logic              rel_valid;
  logic              rel_ready = 1'b0;
  logic [PTR_W-1:0]  rel_ptr;
  logic [NTF_W-1:0]  rel_ntf;
  logic [TS_W-1:0]   rel_ts;
  logic [OWN_W-1:0]  rel_owner;
  logic              rel_first, rel_last, rel_dvalid, link_free, cmd_err;

  mll_releaser #(.NSLOT(NSLOT), .SELF_OWNER(0)) uut (.*);

  always #(CLK_PERIOD / 2) clk = ~clk;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit          finished = 1'b0;

  logic [PTR_W-1:0] mptr [NSLOT];
  logic [NTF_W-1:0] mntf [NSLOT];
  logic [TS_W-1:0]  mts  [NSLOT];

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit all_null();
    for (int i = 0; i < NSLOT; i++) if (mptr[i] != '0) return 1'b0;
    return 1'b1;
  endfunction

  task automatic put(int s, logic [PTR_W-1:0] p, logic [NTF_W-1:0] n, logic [TS_W-1:0] t);
    @(negedge clk);
    wr_en = 1'b1; wr_slot = IDX_W'(s); wr_ptr = p; wr_ntf = n; wr_ts = t;
    @(negedge clk);
    wr_en = 1'b0;
    mptr[s] = p; mntf[s] = n; mts[s] = t;
  endtask

  task automatic run_cmd(int first, int typ, int owner);
    bit ok, fin, isfirst, explast, r;
    int j;
    @(negedge clk);
    chk("R9 ready before command", cmd_ready, 1);
    cmd_valid = 1'b1; cmd_first = IDX_W'(first); cmd_type = TYPE_W'(typ); cmd_owner = OWN_W'(owner);
    ok = (first < NSLOT) && (typ == 1);
    if (ok) ok = (mptr[first] != '0);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (!ok) begin
      chk("R6 error pulse", cmd_err, 1);
      chk("R6 no entry", rel_valid, 0);
      @(negedge clk);
      chk("R6 pulse one cycle", cmd_err, 0);
      chk("R6 still no entry", rel_valid, 0);
      chk("R6 ready again", cmd_ready, 1);
    end else begin
      chk("R6 no error on good command", cmd_err, 0);
      j = first; isfirst = 1'b1; fin = 1'b0;
      while (!fin) begin
        explast = (j == NSLOT - 1) ? 1'b1 : (mptr[j+1] == '0);
        chk("R2 entry valid", rel_valid, 1);
        chk("R2 pointer", rel_ptr, mptr[j]);
        chk("R2 notify", rel_ntf, mntf[j]);
        chk("R2 timestamp", rel_ts, mts[j]);
        chk("R3 first flag", rel_first, isfirst);
        chk("R3 last flag", rel_last, explast);
        chk("R8 owner echo", rel_owner, owner);
        chk("R8 details valid", rel_dvalid, owner != 0);
        chk("R9 busy", cmd_ready, 0);
        r = ($urandom % 4) != 0;
        rel_ready = r;
        @(negedge clk);
        rel_ready = 1'b0;
        if (r) begin
          mptr[j] = '0;
          if (explast) fin = 1'b1;
          else begin j++; isfirst = 1'b0; end
        end
      end
      chk("R7 free strobe after final entry", link_free, all_null());
      chk("R2 stream idle after walk", rel_valid, 0);
      chk("R9 ready after walk", cmd_ready, 1);
      @(negedge clk);
      chk("R7 free strobe one cycle", link_free, 0);
    end
  endtask

  function automatic logic [PTR_W-1:0] rnd_ptr();
    logic [PTR_W-1:0] p;
    p = PTR_W'({$urandom, $urandom});
    if (p == '0) p = 1;
    return p;
  endfunction

  task automatic clear_all();
    for (int i = 0; i < NSLOT; i++) put(i, '0, '0, '0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < NSLOT; i++) begin mptr[i] = '0; mntf[i] = '0; mts[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rel_valid reset", rel_valid, 0);
    chk("R1 link_free reset", link_free, 0);
    chk("R1 cmd_err reset", cmd_err, 0);
    chk("R1 cmd_ready reset", cmd_ready, 1);
    run_cmd(0, 1, 0);                         // R1: table empty, so refused

    // full descriptor, walk to slot 6, then freed
    for (int i = 0; i < NSLOT; i++) put(i, rnd_ptr(), NTF_W'($urandom), TS_W'($urandom));
    run_cmd(0, 1, 5);
    // two MPDUs separated by a null slot
    for (int i = 0; i < NSLOT; i++) put(i, rnd_ptr(), NTF_W'($urandom), TS_W'($urandom));
    put(3, '0, '0, '0);
    run_cmd(0, 1, 0);                         // slots 0..2, not freed
    run_cmd(1, 1, 0);                         // R4: released slot now null
    run_cmd(4, 1, 2);                         // slots 4..6, then freed
    // single MSDU at slot 6
    put(6, rnd_ptr(), 3'd7, 19'h7ffff);
    run_cmd(6, 1, 9);
    // bad commands: index above range, wrong type, null start
    put(2, rnd_ptr(), 3'd1, 19'h1);
    run_cmd(7, 1, 0);
    run_cmd(15, 1, 0);
    run_cmd(2, 2, 0);
    run_cmd(2, 0, 0);
    run_cmd(5, 1, 0);
    run_cmd(2, 1, 0);                         // table intact after refusals (R6)

    for (int it = 0; it < 400; it++) begin
      int nw;
      nw = int'($urandom % 5);
      for (int k = 0; k < nw; k++) begin
        if ($urandom % 3 == 0) put(int'($urandom % NSLOT), '0, '0, '0);
        else put(int'($urandom % NSLOT), rnd_ptr(), NTF_W'($urandom), TS_W'($urandom));
      end
      if ($urandom % 16 == 0) clear_all();
      run_cmd(int'($urandom % 9), ($urandom % 8 == 0) ? int'($urandom % 8) : 1,
              ($urandom % 2 == 0) ? 0 : int'($urandom % 16));
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog (all requirements): got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule